// File: doc/BRIEF.md
# Configurable Memory Traffic Generator

This block keeps a simple memory command port busy with a steady stream of test transactions so that throughput and latency of a memory path can be measured. A small set of static inputs picks the transfer direction, the way successive addresses are produced, and the number of 64-bit words fetched per read. Exactly one command is in flight at any moment: the generator presents it, holds it until the controller takes it, waits for the transaction to finish (acceptance for a write, every data beat for a read), reports completion with a one-cycle pulse, and only then starts the next one.

Addresses are byte addresses covering a 4 MB window built from 2^19 eight-byte words. Four sequencing modes are available: a fixed address, an ascending or descending walk that strides by the transfer length and wraps inside the window, and a pseudo-random pattern taken from a maximal-length shift register. A pause input stops new commands between transactions. The completion pulses feed a separate statistics block.

Top module: `memtraffic_gen`

## Requirements
- R1: After reset `cmd_valid`, `done_rd` and `done_wr` are 0 and `cmd_addr` is 0.
- R2: `dir_write`=1 produces commands with `cmd_write`=1 and `cmd_len`=1 whatever `burst_log` holds; `dir_write`=0 produces `cmd_write`=0 and `cmd_len`=2^`burst_log` (`burst_log` 0..7, so 1..128 words).
- R3: `cmd_addr` is a 22-bit byte address whose low three bits are zero (word address times 8); with `addr_mode`=0 (fixed) the word address never changes.
- R4: With `addr_mode`=1 (ascending) each completed transaction adds its `cmd_len` to the word address, modulo 2^19.
- R5: With `addr_mode`=2 (descending) each completed transaction subtracts its `cmd_len` from the word address, modulo 2^19.
- R6: With `addr_mode`=3 (random) a 19-bit register, seeded with 1 at reset, steps once per completed transaction as s' = {s[17:0], s[18]^s[17]^s[16]^s[13]}, and the next word address takes the new value.
- R7: Once `cmd_valid` rises it stays high, with `cmd_addr`, `cmd_len`, `cmd_write` and `cmd_wdata` unchanged, until a cycle with `cmd_ready` high.
- R8: A read completes only after exactly `cmd_len` cycles with `rd_valid` high following acceptance; no new command is presented while beats are still owed.
- R9: A write completes in the cycle the controller accepts it.
- R10: Every completed read gives one single-cycle `done_rd` pulse and every completed write one `done_wr` pulse, in the cycle after completion; the two never coincide.
- R11: While `pause` is high the generator presents no new command; a transaction already begun still finishes.
- R12: Direction, address mode and burst length are captured when a command is started; changes on those inputs during a transaction affect only later transactions.
- R13: For writes, the low 32 bits of `cmd_wdata` hold the zero-extended word address and the high 32 bits hold their bitwise inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause | input | 1 | Hold off new commands |
| dir_write | input | 1 | 1 = writes, 0 = reads |
| addr_mode | input | 2 | 0 fixed, 1 ascending, 2 descending, 3 random |
| burst_log | input | 3 | log2 of read length in words |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Controller accepts the command |
| cmd_write | output | 1 | Command is a write |
| cmd_addr | output | 22 | Byte address of the command |
| cmd_len | output | 8 | Length in 64-bit words |
| cmd_wdata | output | 64 | Write data pattern |
| rd_valid | input | 1 | One read data beat returned |
| done_rd | output | 1 | Read completion pulse |
| done_wr | output | 1 | Write completion pulse |

## Verification
A corrupted address register or shift-register state shows at `cmd_addr` on the very next command, so a scoreboard that predicts every command from its own address model catches it one transaction later at most. A beat counter that miscounts shows either as a command appearing while the bench still owes data or as a hang that the pause-and-drain step exposes within a phase. Wrongly latched configuration appears as a mismatched `cmd_len` or `cmd_write` on the command after a mid-transaction input change, and misplaced completion pulses show as pulse counts that disagree with the number of accepted commands at the end of each phase.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

   typedef enum logic [1:0] {
      AM_FIXED  = 2'd0,
      AM_UP     = 2'd1,
      AM_DOWN   = 2'd2,
      AM_RANDOM = 2'd3
   } addr_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DRAIN = 2'd2
   } gen_state_e;

endpackage

// File: rtl/mtg_addr_seq.sv
module mtg_addr_seq
   import mtg_pkg::*;
#(
   parameter int WORD_AW = 19,
   parameter int LEN_W   = 8,
   parameter logic [WORD_AW-1:0] SEED = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance,
   input  addr_mode_e         mode,
   input  logic [LEN_W-1:0]   step,
   output logic [WORD_AW-1:0] word_addr
);

   logic [WORD_AW-1:0] cur_q;
   logic [WORD_AW-1:0] lfsr_q;
   logic [WORD_AW-1:0] lfsr_nxt;
   logic [WORD_AW-1:0] step_ext;
   logic               fb;

   generate
      if (WORD_AW == 19) begin : g_poly19
         assign fb = lfsr_q[18] ^ lfsr_q[17] ^ lfsr_q[16] ^ lfsr_q[13];
      end else if (WORD_AW == 20) begin : g_poly20
         assign fb = lfsr_q[19] ^ lfsr_q[16];
      end else if (WORD_AW == 21) begin : g_poly21
         assign fb = lfsr_q[20] ^ lfsr_q[18];
      end else if (WORD_AW == 22) begin : g_poly22
         assign fb = lfsr_q[21] ^ lfsr_q[20];
      end else begin : g_poly_bad
         $error("mtg_addr_seq: WORD_AW must be 19..22");
         assign fb = 1'b0;
      end
      if (LEN_W > WORD_AW) begin : g_len_bad
         $error("mtg_addr_seq: LEN_W must not exceed WORD_AW");
      end
      if (SEED == '0) begin : g_seed_bad
         $error("mtg_addr_seq: SEED must be nonzero");
      end
   endgenerate

   assign lfsr_nxt = {lfsr_q[WORD_AW-2:0], fb};
   assign step_ext = WORD_AW'(step);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         lfsr_q <= SEED;
      end else if (advance) begin
         unique case (mode)
            AM_FIXED:  cur_q <= cur_q;
            AM_UP:     cur_q <= cur_q + step_ext;
            AM_DOWN:   cur_q <= cur_q - step_ext;
            AM_RANDOM: begin
               lfsr_q <= lfsr_nxt;
               cur_q  <= lfsr_nxt;
            end
            default:   cur_q <= cur_q;
         endcase
      end
   end

   assign word_addr = cur_q;

   // R6: the shift register must never fall into the all-zero lock state
   assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

   // R3: fixed mode leaves the address alone across a completion
   assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && mode == AM_FIXED) |=> $stable(word_addr));

   // R6: a random-mode completion loads the address from the new register state
   assert_rand_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && mode == AM_RANDOM) |=> (word_addr == lfsr_q));

endmodule

// File: rtl/mtg_beat_cnt.sv
module mtg_beat_cnt #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_len,
   input  logic             beat,
   output logic             busy,
   output logic             last
);

   logic [LEN_W-1:0] remain_q;

   generate
      if (LEN_W < 1) begin : g_len_bad
         $error("mtg_beat_cnt: LEN_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= load_len;
      end else if (beat && busy) begin
         remain_q <= remain_q - LEN_W'(1);
      end
   end

   assign busy = (remain_q != '0);
   assign last = beat && (remain_q == LEN_W'(1));

   // R8: data beats arrive only while a read still owes them
   assert_no_extra_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      beat |-> busy);

   // R8: a load only happens with nothing outstanding
   assert_load_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);

endmodule

// File: rtl/memtraffic_gen.sv
module memtraffic_gen
   import mtg_pkg::*;
#(
   parameter int WORD_AW  = 19,
   parameter int DATA_W   = 64,
   parameter int MAX_BLOG = 7,
   parameter int BLOG_W   = $clog2(MAX_BLOG + 1),
   parameter int LEN_W    = MAX_BLOG + 1,
   parameter int BYTE_AW  = WORD_AW + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pause,
   input  logic              dir_write,
   input  logic [1:0]        addr_mode,
   input  logic [BLOG_W-1:0] burst_log,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic              cmd_write,
   output logic [BYTE_AW-1:0] cmd_addr,
   output logic [LEN_W-1:0]  cmd_len,
   output logic [DATA_W-1:0] cmd_wdata,
   input  logic              rd_valid,
   output logic              done_rd,
   output logic              done_wr
);

   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0 || HALF_W < WORD_AW) begin : g_data_bad
         $error("memtraffic_gen: DATA_W must be even and hold two word addresses");
      end
      if (MAX_BLOG < 0 || MAX_BLOG > 15) begin : g_blog_bad
         $error("memtraffic_gen: MAX_BLOG out of range");
      end
      if (BYTE_AW != WORD_AW + 3) begin : g_aw_bad
         $error("memtraffic_gen: BYTE_AW must equal WORD_AW + 3");
      end
   endgenerate

   gen_state_e        state_q;
   logic              wr_q;
   addr_mode_e        mode_q;
   logic [LEN_W-1:0]  len_q;
   logic              done_rd_q;
   logic              done_wr_q;
   logic [BLOG_W-1:0] blog_eff;
   logic              accept;
   logic              advance;
   logic              load_beats;
   logic              beats_busy;
   logic              beats_last;
   logic [WORD_AW-1:0] word_addr;
   logic [HALF_W-1:0] wd_lo;

   assign blog_eff   = (burst_log > BLOG_W'(MAX_BLOG)) ? BLOG_W'(MAX_BLOG) : burst_log;
   assign accept     = (state_q == ST_ISSUE) && cmd_ready;
   assign load_beats = accept && !wr_q;
   assign advance    = (accept && wr_q) || ((state_q == ST_DRAIN) && beats_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         wr_q      <= 1'b0;
         mode_q    <= AM_FIXED;
         len_q     <= LEN_W'(1);
         done_rd_q <= 1'b0;
         done_wr_q <= 1'b0;
      end else begin
         done_rd_q <= 1'b0;
         done_wr_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (!pause) begin
                  wr_q    <= dir_write;
                  mode_q  <= addr_mode_e'(addr_mode);
                  len_q   <= dir_write ? LEN_W'(1) : (LEN_W'(1) << blog_eff);
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (cmd_ready) begin
                  if (wr_q) begin
                     done_wr_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end else begin
                     state_q   <= ST_DRAIN;
                  end
               end
            end
            ST_DRAIN: begin
               if (beats_last) begin
                  done_rd_q <= 1'b1;
                  state_q   <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   mtg_addr_seq #(
      .WORD_AW (WORD_AW),
      .LEN_W   (LEN_W)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .mode      (mode_q),
      .step      (len_q),
      .word_addr (word_addr)
   );

   mtg_beat_cnt #(
      .LEN_W (LEN_W)
   ) u_beats (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_beats),
      .load_len (len_q),
      .beat     (rd_valid && (state_q == ST_DRAIN)),
      .busy     (beats_busy),
      .last     (beats_last)
   );

   assign wd_lo     = HALF_W'(word_addr);
   assign cmd_valid = (state_q == ST_ISSUE);
   assign cmd_write = wr_q;
   assign cmd_len   = len_q;
   assign cmd_addr  = {word_addr, 3'b000};
   assign cmd_wdata = {~wd_lo, wd_lo};
   assign done_rd   = done_rd_q;
   assign done_wr   = done_wr_q;

   // R7: an offered command stays put until taken
   assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                      && $stable(cmd_len) && $stable(cmd_write)));

   // R2: writes are always single-word
   assert_write_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write) |-> (cmd_len == LEN_W'(1)));

   // R8: no command while read data is still owed
   assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      beats_busy |-> !cmd_valid);

   // R10: completion pulses are exclusive and last one cycle
   assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_rd, done_wr}));
   assert_done_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_rd |=> !done_rd);
   assert_done_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_wr |=> !done_wr);

   // R11: a paused idle generator offers nothing next cycle
   assert_pause_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && pause) |=> !cmd_valid);

   // R12: captured length is frozen while a transaction runs
   assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(cmd_len));

endmodule

// File: tb/memtraffic_gen_tb.sv
module memtraffic_gen_tb;

   typedef struct {
      bit          wr;
      logic [21:0] addr;
      int          len;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pause = 1'b1;
   logic        dir_write = 1'b0;
   logic [1:0]  addr_mode = 2'd0;
   logic [2:0]  burst_log = 3'd0;
   logic        cmd_ready = 1'b0;
   logic        rd_valid = 1'b0;
   logic        cmd_valid;
   logic        cmd_write;
   logic [21:0] cmd_addr;
   logic [7:0]  cmd_len;
   logic [63:0] cmd_wdata;
   logic        done_rd;
   logic        done_wr;

   int checks = 0;
   int failures = 0;
   exp_t exp_q[$];
   int pending = 0;
   int tick = 0;
   int n_rd = 0;
   int n_wr = 0;
   bit was_wait = 0;
   logic [21:0] held_addr;
   logic [18:0] m_cur = '0;
   logic [18:0] m_lfsr = 19'd1;

   always #10 clk = ~clk;

   memtraffic_gen u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pause     (pause),
      .dir_write (dir_write),
      .addr_mode (addr_mode),
      .burst_log (burst_log),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_write (cmd_write),
      .cmd_addr  (cmd_addr),
      .cmd_len   (cmd_len),
      .cmd_wdata (cmd_wdata),
      .rd_valid  (rd_valid),
      .done_rd   (done_rd),
      .done_wr   (done_wr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [18:0] lfsr_step(input logic [18:0] s);
      return {s[17:0], s[18] ^ s[17] ^ s[16] ^ s[13]};
   endfunction

   // driver side: predict the command stream from the requirements
   task automatic push_items(input bit wr, input int mode, input int blog, input int n);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.wr   = wr;
         e.len  = wr ? 1 : (1 << blog);
         e.addr = {m_cur, 3'b000};
         exp_q.push_back(e);
         case (mode)
            1: m_cur = m_cur + 19'(e.len);
            2: m_cur = m_cur - 19'(e.len);
            3: begin m_lfsr = lfsr_step(m_lfsr); m_cur = m_lfsr; end
            default: m_cur = m_cur;
         endcase
      end
   endtask

   task automatic drain_and_check(input int exp_rd, input int exp_wr, input string req);
      while (exp_q.size() != 0 || pending != 0) @(negedge clk);
      repeat (12) @(negedge clk);
      chk(n_rd == exp_rd, "R10", {req, " done_rd count"}, n_rd, exp_rd);
      chk(n_wr == exp_wr, "R10", {req, " done_wr count"}, n_wr, exp_wr);
      chk(cmd_valid == 1'b0, "R11", {req, " idle while paused"}, cmd_valid, 0);
   endtask

   task automatic run_phase(input bit wr, input int mode, input int blog, input int n,
                            input string req);
      @(negedge clk);
      dir_write = wr;
      addr_mode = 2'(mode);
      burst_log = 3'(blog);
      push_items(wr, mode, blog, n);
      n_rd = 0;
      n_wr = 0;
      pause = 1'b0;
      drain_and_check(wr ? 0 : n, wr ? n : 0, req);
   endtask

   // monitor and memory responder, all at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_valid) pending--;
         if (done_rd) n_rd++;
         if (done_wr) n_wr++;
         if (cmd_valid && pending > 0)
            chk(0, "R8", "command while beats owed", pending, 0);
         if (was_wait) begin
            chk(cmd_valid, "R7", "valid dropped before accept", cmd_valid, 1);
            chk(cmd_addr == held_addr, "R7", "address moved while waiting", cmd_addr, held_addr);
         end
         rd_valid  = (pending > 0) && (tick % 3 != 1);
         cmd_ready = (tick % 4 != 0);
         if (cmd_valid && exp_q.size() == 0) begin
            chk(0, "R11", "command issued while none expected", cmd_addr, 0);
            cmd_ready = 1'b0;
            was_wait  = 0;
         end else if (cmd_valid && cmd_ready) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(cmd_write == e.wr, e.wr ? "R9" : "R2", "direction", cmd_write, e.wr);
            chk(cmd_len == 8'(e.len), "R2", "length", cmd_len, e.len);
            chk(cmd_addr == e.addr, "R4", "address sequence", cmd_addr, e.addr);
            chk(cmd_addr[2:0] == 3'b000, "R3", "byte alignment", cmd_addr[2:0], 0);
            if (e.wr) begin
               logic [31:0] lo;
               lo = {13'b0, e.addr[21:3]};
               chk(cmd_wdata == {~lo, lo}, "R13", "write data", cmd_wdata, {~lo, lo});
            end else begin
               pending = e.len;
            end
            if (exp_q.size() == 0) pause = 1'b1;
            was_wait = 0;
         end else if (cmd_valid) begin
            was_wait  = 1;
            held_addr = cmd_addr;
         end else begin
            was_wait = 0;
         end
         tick++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(cmd_valid == 1'b0, "R1", "valid in reset", cmd_valid, 0);
      chk(done_rd == 1'b0 && done_wr == 1'b0, "R1", "done in reset", {done_rd, done_wr}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(cmd_valid == 1'b0, "R11", "paused after reset", cmd_valid, 0);
      chk(cmd_addr == 22'd0, "R1", "address after reset", cmd_addr, 0);

      run_phase(1'b1, 1, 5, 6, "R2 R4 R9 R13 write ascending");
      run_phase(1'b0, 1, 3, 5, "R2 R4 R8 read ascending burst 8");
      run_phase(1'b0, 2, 7, 3, "R5 read descending burst 128 wrap");
      run_phase(1'b0, 0, 0, 4, "R3 read fixed single");
      run_phase(1'b1, 3, 2, 6, "R6 write random");
      run_phase(1'b0, 3, 1, 4, "R6 read random burst 2");
      run_phase(1'b1, 2, 0, 4, "R5 write descending");

      // R12: change inputs while a 16-word read is in progress
      @(negedge clk);
      dir_write = 1'b0;
      addr_mode = 2'd1;
      burst_log = 3'd4;
      push_items(1'b0, 1, 4, 1);
      push_items(1'b1, 1, 0, 1);
      n_rd = 0;
      n_wr = 0;
      pause = 1'b0;
      while (pending == 0) @(negedge clk);
      dir_write = 1'b1;
      burst_log = 3'd0;
      drain_and_check(1, 1, "R12 mid-read change");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule